// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach a bank of byte-wide internal registers through one control address. A hidden phase decides what each access means. In the pointer phase, a host write picks a register number. The port then moves to the data phase, where exactly one host read or write reaches the selected register. After that access the port drops back to the pointer phase. The host sees only a chip select, a read strobe, a write strobe and an 8-bit data bus.

Bit 0 of register 0 is a reset control. If the host sets it through a data-phase write, the port enters a reset phase and clears the whole register bank. Register 0 is the interrupt control byte and register 1 is the master configuration byte, so both read 0x00 after a reset: interrupts are off, and all ports and counters are disabled. In the reset phase a read returns a flag and leaves the phase as it is. A write with bit 0 clear ends the reset phase.

Because of these rules, the host sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 always leaves the port in the pointer phase with a cleared bank, whatever phase it started in. A driver uses this sequence when it cannot know the phase.

Top module: `iap_port`

## Requirements
- R1: After `rst_ni` is released, the port is in the reset phase. A read there returns 0x01 and leaves the port in the reset phase.
- R2: In the reset phase, a write with bit 0 clear moves the port to the pointer phase. A write with bit 0 set keeps the port in the reset phase.
- R3: In the pointer phase, a write stores the low 6 bits of the data as the pointer (register number modulo 64) and moves the port to the data phase.
- R4: In the data phase, a write stores the byte in the register at the pointer and returns the port to the pointer phase.
- R5: In the data phase, a read returns the register at the pointer on `rdata_o` in the cycle of the strobe and returns the port to the pointer phase.
- R6: In the pointer phase, a read returns the register at the current pointer and does not change the phase or the pointer.
- R7: In the data phase, a write with bit 0 set to register 0 enters the reset phase and clears all 64 registers and the pointer to 0x00 at that edge. A write to register 0 with bit 0 clear is stored like any other write.
- R8: The sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 leaves the port in the pointer phase with every register at 0x00. This holds whether it starts in the pointer, data or reset phase.
- R9: A strobe with `cs_i` low, or with `rd_i` and `wr_i` both high, has no effect. `rdata_o` is 0x00 whenever no valid read strobe is present.
- R10: `in_reset_o` is high exactly while the port is in the reset phase. `int_ctrl_o` and `cfg_o` always show registers 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select for the control address |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| wdata_i | input | 8 | Host write data (pointer or register data) |
| rdata_o | output | 8 | Host read data, valid in the strobe cycle |
| in_reset_o | output | 1 | Port is in the reset phase |
| int_ctrl_o | output | 8 | Contents of register 0 (interrupt control) |
| cfg_o | output | 8 | Contents of register 1 (master configuration) |

## Verification
The assertions assume a synchronous host:
- `cs_i`, `rd_i`, `wr_i` and `wdata_i` change only between clock edges.
- Each strobe lasts one cycle.
- The phase and the pointer move only on a qualified strobe.

The bench meets these assumptions by driving every bus cycle on the falling edge and dropping the strobes just after the rising edge that samples them. Illegal patterns (no chip select, read and write together) are issued as whole cycles in the same way. The reference model follows the phase and the pointer, so the expected data is known for every read.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_PTR   = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;
endpackage

// File: rtl/iap_bus_decode.sv
module iap_bus_decode (
  input  logic cs_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic rd_stb_o,
  output logic wr_stb_o
);
  // rd and wr together is treated as no access
  assign rd_stb_o = cs_i & rd_i & ~wr_i;
  assign wr_stb_o = cs_i & wr_i & ~rd_i;
endmodule

// File: rtl/iap_phase_fsm.sv
module iap_phase_fsm
  import iap_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_stb_i,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] ptr_data_i,
  input  logic          rst_bit_i,
  output phase_e        phase_o,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic          clr_o
);
  phase_e        phase_q, phase_d;
  logic [AW-1:0] ptr_q;

  always_comb begin
    phase_d = phase_q;
    we_o    = 1'b0;
    clr_o   = (phase_q == PH_RESET);
    unique case (phase_q)
      PH_RESET: if (wr_stb_i && !rst_bit_i) phase_d = PH_PTR;
      PH_PTR:   if (wr_stb_i) phase_d = PH_DATA;
      PH_DATA: begin
        if (wr_stb_i) begin
          if (ptr_q == '0 && rst_bit_i) begin
            phase_d = PH_RESET;
            clr_o   = 1'b1;
          end else begin
            we_o    = 1'b1;
            phase_d = PH_PTR;
          end
        end else if (rd_stb_i) begin
          phase_d = PH_PTR;
        end
      end
      default: phase_d = PH_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RESET;
      ptr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (clr_o) ptr_q <= '0;
      else if (phase_q == PH_PTR && wr_stb_i) ptr_q <= ptr_data_i;
    end
  end

  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;

  // R1
  rst_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RESET && rd_stb_i) |=> (phase_q == PH_RESET));

  // R3
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PTR && wr_stb_i) |=> (phase_q == PH_DATA && ptr_q == $past(ptr_data_i)));

  // R5
  data_read_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && rd_stb_i && !wr_stb_i) |=> (phase_q == PH_PTR));

  // R6
  ptr_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PTR && rd_stb_i) |=> (phase_q == PH_PTR && $stable(ptr_q)));

  // R7
  reset_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && wr_stb_i && ptr_q == '0 && rst_bit_i) |=> (phase_q == PH_RESET && ptr_q == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i || wr_stb_i) |=> ($stable(phase_q) && $stable(ptr_q)));
endmodule

// File: rtl/iap_reg_bank.sv
module iap_reg_bank #(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned DW       = 8,
  parameter int unsigned CFG_IDX  = 1,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] reg0_o,
  output logic [DW-1:0] regc_o
);
  logic [NUM_REGS-1:0][DW-1:0] mem_q;
  logic [NUM_REGS-1:0]         wsel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wsel[i] = we_i && (addr_i == AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (clr_i) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wsel[i]) mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[addr_i];
  assign reg0_o  = mem_q[0];
  assign regc_o  = mem_q[CFG_IDX];

  // R7
  bank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mem_q == '0));

  // R4
  bank_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/iap_port.sv
module iap_port
  import iap_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned CFG_IDX  = 1,
  parameter logic [7:0]  RST_FLAG = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       in_reset_o,
  output logic [7:0] int_ctrl_o,
  output logic [7:0] cfg_o
);
  localparam int unsigned AW = $clog2(NUM_REGS);

  logic          rd_stb, wr_stb, bank_we, bank_clr;
  phase_e        phase;
  logic [AW-1:0] ptr;
  logic [7:0]    bank_rd;

  iap_bus_decode u_dec (
    .cs_i     (cs_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .rd_stb_o (rd_stb),
    .wr_stb_o (wr_stb)
  );

  iap_phase_fsm #(.AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_stb_i   (rd_stb),
    .wr_stb_i   (wr_stb),
    .ptr_data_i (wdata_i[AW-1:0]),
    .rst_bit_i  (wdata_i[0]),
    .phase_o    (phase),
    .ptr_o      (ptr),
    .we_o       (bank_we),
    .clr_o      (bank_clr)
  );

  iap_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DW       (BYTE_W),
    .CFG_IDX  (CFG_IDX)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bank_clr),
    .we_i    (bank_we),
    .addr_i  (ptr),
    .wdata_i (wdata_i),
    .rdata_o (bank_rd),
    .reg0_o  (int_ctrl_o),
    .regc_o  (cfg_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_stb) rdata_o = (phase == PH_RESET) ? RST_FLAG : bank_rd;
  end

  assign in_reset_o = (phase == PH_RESET);

  // R10
  reset_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reset_o |-> (int_ctrl_o == '0 || $past(bank_clr) == 1'b0));

  // R9
  no_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i && !wr_i) |-> (rdata_o == '0));
endmodule

// File: tb/tb_iap_port.sv
module tb_iap_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, int_ctrl_o, cfg_o;
  logic       in_reset_o;

  iap_port dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .in_reset_o (in_reset_o),
    .int_ctrl_o (int_ctrl_o),
    .cfg_o      (cfg_o)
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  // reference model: 0 reset phase, 1 pointer phase, 2 data phase
  int         m_ph = 0;
  int         m_ptr = 0;
  logic [7:0] m_reg [64];

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
    m_ptr = 0;
  endtask

  task automatic bus(input logic c, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = c; rd_i = r; wr_i = w; wdata_i = d;
    @(posedge clk_i);
    #1;
    cs_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d);
    case (m_ph)
      0: begin m_clear(); if (!d[0]) m_ph = 1; end
      1: begin m_ptr = d % 64; m_ph = 2; end
      default: begin
        if (m_ptr == 0 && d[0]) begin m_clear(); m_ph = 0; end
        else begin m_reg[m_ptr] = d; m_ph = 1; end
      end
    endcase
    bus(1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic host_rd(input string tag);
    q_exp.push_back((m_ph == 0) ? 8'h01 : m_reg[m_ptr]);
    q_tag.push_back(tag);
    if (m_ph == 2) m_ph = 1;
    bus(1'b1, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic side_check(input string tag);
    check8({tag, " in_reset"}, {7'd0, in_reset_o}, {7'd0, (m_ph == 0)});
    check8({tag, " int_ctrl"}, int_ctrl_o, m_reg[0]);
    check8({tag, " cfg"}, cfg_o, m_reg[1]);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    host_wr(a);
    host_wr(d);
  endtask

  // R8 recovery sequence
  task automatic recover(input string tag);
    host_rd(tag);
    host_wr(8'h00);
    host_rd(tag);
    host_wr(8'h00);
    host_wr(8'h01);
    host_wr(8'h00);
  endtask

  // monitor: pops expected read data and compares in the strobe cycle
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (cs_i && rd_i && !wr_i) begin
        if (q_exp.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5: actual %02h expected no read", rdata_o);
        end else begin
          string      t;
          logic [7:0] e;
          t = q_tag.pop_front();
          e = q_exp.pop_front();
          check8(t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #3;
    side_check("R1 R10 reset");
    check8("R9 idle rdata", rdata_o, 8'h00);

    // R1: reads in reset phase
    host_rd("R1 flag");
    host_rd("R1 flag again");
    // R2: bit0 set keeps reset, clear releases
    host_wr(8'h01);
    side_check("R2 stay");
    host_wr(8'h00);
    side_check("R2 release");

    // R3 R4 R5
    reg_wr(8'd5, 8'hA5);
    host_wr(8'd69);
    host_rd("R3 wrap R5 read");
    reg_wr(8'd63, 8'h5A);
    host_wr(8'd127);
    host_rd("R3 top wrap");
    // R6: pointer-phase reads
    host_rd("R6 ptr read");
    host_rd("R6 ptr read again");
    reg_wr(8'd1, 8'h3C);
    side_check("R10 cfg mirror");
    reg_wr(8'd0, 8'h82);
    side_check("R7 bit0 clear stores");
    host_wr(8'd0);
    host_rd("R5 read reg0");

    // R9: ignored strobes
    host_wr(8'd5);
    bus(1'b0, 1'b0, 1'b1, 8'h77);
    bus(1'b0, 1'b1, 1'b0, 8'h00);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; wr_i = 1'b1; wdata_i = 8'h99;
    #2;
    check8("R9 rd+wr rdata", rdata_o, 8'h00);
    @(posedge clk_i);
    #1;
    cs_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
    host_rd("R9 still data phase");
    host_rd("R9 ptr kept");

    // R7: reset bit via register 0
    reg_wr(8'd0, 8'h03);
    side_check("R7 reset entry");
    host_rd("R7 flag");
    host_wr(8'h00);
    host_wr(8'd5);
    host_rd("R7 bank cleared");

    // R8 from pointer phase
    reg_wr(8'd1, 8'h11);
    reg_wr(8'd9, 8'h99);
    recover("R8 from ptr");
    side_check("R8 ptr");
    host_wr(8'd9);
    host_rd("R8 ptr probe");
    // R8 from data phase
    reg_wr(8'd1, 8'h22);
    reg_wr(8'd9, 8'h44);
    host_wr(8'd9);
    recover("R8 from data");
    side_check("R8 data");
    host_wr(8'd9);
    host_rd("R8 data probe");
    // R8 from reset phase
    reg_wr(8'd1, 8'h33);
    reg_wr(8'd0, 8'h01);
    recover("R8 from reset");
    side_check("R8 reset");
    host_wr(8'd1);
    host_rd("R8 reset probe");

    repeat (3) @(posedge clk_i);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R5: actual %0d pending reads expected 0", q_exp.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule